// File: doc/BRIEF.md
# Byte-Serial Debug Port Command Decoder

This block is the target end of a debug link. A host feeds it a stream of command bytes through a valid/ready byte input. The block decodes each one-byte opcode and collects any operand bytes. It then performs one of these actions:

- load its address pointer;
- read or write a core register, an auxiliary register or a memory word at that pointer;
- access a small control byte that halts or single-steps up to three processors.

Reads go out as a single request on a synchronous bus toward the debugged system. The word that comes back is returned to the host through a valid/ready byte output, most significant byte first.

Each opcode carries bit fields for the space, the direction and post-increment. Register accesses can advance the pointer by one, and memory accesses always advance it by one word. The control byte keeps a halt bit for each processor. Its step bits act once and then clear themselves. An auxiliary write to a processor's status slot can also release that processor from halt.

Top module: `dbgp_port`

## Requirements
- R1: After synchronous active-high reset, the address pointer is 0, all `cpu_step` bits are 0, `cpu_halt` is all ones, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: Opcode 0x00 followed by four bytes, most significant first, loads the address pointer. The next access uses the pointer as its `bus_addr`.
- R3: Opcode 0x41 writes a core register (`bus_space` 0) and opcode 0x81 writes an auxiliary register (`bus_space` 1). Each takes four data bytes, most significant first, and issues exactly one request with `bus_we`=1, `bus_addr` equal to the pointer and `bus_wdata` equal to the assembled word. `bus_space` value 3 never appears.
- R4: Setting opcode bit 4 (0x51, 0x91, 0x71, 0xB1) makes the access a read. It issues one request with `bus_we`=0, then returns the `bus_rdata` word as four output bytes, most significant first.
- R5: Setting opcode bit 5 on a register access (0x61, 0x71, 0xA1, 0xB1) adds 1 to the pointer after the access. Without that bit the pointer is unchanged.
- R6: Opcode 0x21 writes a memory word (`bus_space` 2) from four data bytes. Opcode 0x31 reads a memory word and returns four bytes. Both add 4 to the pointer after the access.
- R7: Opcode 0x02 followed by one byte writes the control byte. Bits 3, 4 and 5 set the halt state of processors 0, 1 and 2, and `cpu_halt` follows on the cycle after the write executes.
- R8: Control bits 0, 1 and 2 give a `cpu_step` pulse of exactly one cycle to processors 0, 1 and 2. Opcode 0x12 returns one byte holding the halt bits at positions 5:3, with step bits 2:0 and bits 7:6 reading 0.
- R9: An auxiliary write (0x81 or 0xA1) whose pointer equals k (k = 0..2) and whose data has bit 25 set clears `cpu_halt[k]` and leaves the other halt bits alone. The write request is still issued. Core writes and data with bit 25 clear do not change halt state.
- R10: Any other opcode byte is dropped. It causes no request and no output byte, and the following byte is decoded as a new opcode.
- R11: From the acceptance of a read opcode until its last output byte is taken, `cmd_ready` is 0. While `rsp_valid` is high and `rsp_ready` is low, `rsp_byte` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command byte is valid |
| cmd_byte | input | 8 | Host command or operand byte |
| cmd_ready | output | 1 | Block accepts a command byte this cycle |
| rsp_valid | output | 1 | Response byte is valid |
| rsp_byte | output | 8 | Response byte, most significant first |
| rsp_ready | input | 1 | Host takes the response byte |
| bus_req | output | 1 | One-cycle access request to the debugged system |
| bus_we | output | 1 | Request is a write |
| bus_space | output | 2 | 0 core register, 1 auxiliary register, 2 memory |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_rvalid | input | 1 | Read data is returned |
| bus_rdata | input | 32 | Read data word |
| cpu_halt | output | 3 | Halt state per processor |
| cpu_step | output | 3 | One-cycle single-step pulse per processor |

## Verification
A control write that sets step bits can be followed at once by a control read. The step bit then clears itself on the same edge at which the read captures the control byte. The bench provokes this by sending 0x02, the step byte and 0x12 with no gap between them. It judges the result by counting that exactly one step cycle appears with the right processor bits, and by checking that the returned byte shows zero in the step field.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_EXEC,
        ST_WAIT,
        ST_SEND
    } dbgp_state_e;

    typedef enum logic [1:0] {
        SPC_CORE = 2'd0,
        SPC_AUX  = 2'd1,
        SPC_MEM  = 2'd2,
        SPC_NONE = 2'd3
    } dbgp_space_e;

    typedef enum logic [2:0] {
        OP_LDADDR,
        OP_REG_WR,
        OP_REG_RD,
        OP_MEM_WR,
        OP_MEM_RD,
        OP_CTL_WR,
        OP_CTL_RD,
        OP_ILLEGAL
    } dbgp_kind_e;

    typedef struct packed {
        dbgp_kind_e  kind;
        dbgp_space_e space;
        logic        incr;
    } dbgp_cmd_t;

endpackage

// File: rtl/dbgp_opdec.sv
module dbgp_opdec
    import dbgp_pkg::*;
(
    input  logic [7:0] opcode,
    output dbgp_cmd_t  cmd
);

    always_comb begin
        cmd.kind  = OP_ILLEGAL;
        cmd.space = SPC_NONE;
        cmd.incr  = 1'b0;
        case (opcode)
            8'h00: cmd.kind = OP_LDADDR;
            8'h02: cmd.kind = OP_CTL_WR;
            8'h12: cmd.kind = OP_CTL_RD;
            8'h21: begin
                cmd.kind  = OP_MEM_WR;
                cmd.space = SPC_MEM;
                cmd.incr  = 1'b1;
            end
            8'h31: begin
                cmd.kind  = OP_MEM_RD;
                cmd.space = SPC_MEM;
                cmd.incr  = 1'b1;
            end
            8'h41, 8'h51, 8'h61, 8'h71,
            8'h81, 8'h91, 8'hA1, 8'hB1: begin
                // bit 7 picks aux over core, bit 5 post-increment, bit 4 read
                cmd.kind  = opcode[4] ? OP_REG_RD : OP_REG_WR;
                cmd.space = opcode[7] ? SPC_AUX : SPC_CORE;
                cmd.incr  = opcode[5];
            end
            default: cmd.kind = OP_ILLEGAL;
        endcase
    end

endmodule

// File: rtl/dbgp_ctlreg.sv
module dbgp_ctlreg #(
    parameter int NPROC = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2*NPROC-1:0]   wr_bits,
    input  logic [NPROC-1:0]     resume,
    output logic [NPROC-1:0]     halt,
    output logic [NPROC-1:0]     step,
    output logic [7:0]           rd_byte
);

    // layout: step bits [NPROC-1:0], halt bits [2*NPROC-1:NPROC]; needs 2*NPROC <= 8
    typedef struct packed {
        logic [NPROC-1:0] halt;
        logic [NPROC-1:0] step;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.step = '0;
        for (int k = 0; k < NPROC; k++) begin
            if (wr_en) begin
                ctl_d.halt[k] = wr_bits[NPROC + k];
                ctl_d.step[k] = wr_bits[k];
            end else if (resume[k]) begin
                ctl_d.halt[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.halt <= '1;
            ctl_q.step <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign halt = ctl_q.halt;
    assign step = ctl_q.step;

    // step bits are one-shot and always read back as zero
    generate
        if (2 * NPROC < 8) begin : g_pad
            assign rd_byte = {{(8 - 2 * NPROC){1'b0}}, ctl_q.halt, {NPROC{1'b0}}};
        end else begin : g_full
            assign rd_byte = {ctl_q.halt, {NPROC{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/dbgp_txser.sv
module dbgp_txser #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              last_take
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } tx_t;

    tx_t tx_q, tx_d;
    logic take;

    assign out_valid = (tx_q.cnt != '0);
    assign out_byte  = tx_q.word[DATA_W-1 -: 8];
    assign take      = out_valid && out_ready;
    assign last_take = take && (tx_q.cnt == CNT_W'(1));

    always_comb begin
        tx_d = tx_q;
        if (load) begin
            tx_d.word = load_word;
            tx_d.cnt  = load_cnt;
        end else if (take) begin
            tx_d.word = tx_q.word << 8;
            tx_d.cnt  = tx_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

endmodule

// File: rtl/dbgp_port.sv
module dbgp_port
    import dbgp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NPROC      = 3,
    parameter int RESUME_BIT = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [7:0]        rsp_byte,
    input  logic              rsp_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_space,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rvalid,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [NPROC-1:0]  cpu_halt,
    output logic [NPROC-1:0]  cpu_step
);

    localparam int BYTES    = DATA_W / 8;
    localparam int CNT_W    = $clog2(BYTES + 1);
    localparam int MEM_STEP = BYTES;

    typedef struct packed {
        dbgp_state_e       st;
        dbgp_cmd_t         cmd;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic [ADDR_W-1:0] addr;
    } core_t;

    core_t core_q, core_d;

    dbgp_cmd_t         dec;
    logic              ctl_we;
    logic [NPROC-1:0]  resume;
    logic [7:0]        ctl_rbyte;
    logic              tx_load;
    logic [DATA_W-1:0] tx_word;
    logic [CNT_W-1:0]  tx_cnt;
    logic              tx_last;
    logic [ADDR_W-1:0] adv;

    dbgp_opdec u_dec (
        .opcode (cmd_byte),
        .cmd    (dec)
    );

    dbgp_ctlreg #(.NPROC(NPROC)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_we),
        .wr_bits (core_q.shreg[2*NPROC-1:0]),
        .resume  (resume),
        .halt    (cpu_halt),
        .step    (cpu_step),
        .rd_byte (ctl_rbyte)
    );

    dbgp_txser #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_load),
        .load_word (tx_word),
        .load_cnt  (tx_cnt),
        .out_ready (rsp_ready),
        .out_valid (rsp_valid),
        .out_byte  (rsp_byte),
        .last_take (tx_last)
    );

    // pointer advance for the command being executed
    always_comb begin
        if (core_q.cmd.space == SPC_MEM) begin
            adv = ADDR_W'(MEM_STEP);
        end else if (core_q.cmd.incr) begin
            adv = ADDR_W'(1);
        end else begin
            adv = '0;
        end
    end

    always_comb begin
        core_d    = core_q;
        cmd_ready = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_space = core_q.cmd.space;
        bus_addr  = core_q.addr;
        bus_wdata = core_q.shreg;
        ctl_we    = 1'b0;
        resume    = '0;
        tx_load   = 1'b0;
        tx_word   = '0;
        tx_cnt    = '0;

        case (core_q.st)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    core_d.cmd = dec;
                    case (dec.kind)
                        OP_ILLEGAL: core_d.st = ST_IDLE;
                        OP_CTL_RD: begin
                            tx_load   = 1'b1;
                            tx_word   = {ctl_rbyte, {(DATA_W - 8){1'b0}}};
                            tx_cnt    = CNT_W'(1);
                            core_d.st = ST_SEND;
                        end
                        OP_REG_RD, OP_MEM_RD: core_d.st = ST_EXEC;
                        OP_CTL_WR: begin
                            core_d.cnt = CNT_W'(1);
                            core_d.st  = ST_COLLECT;
                        end
                        default: begin
                            core_d.cnt = CNT_W'(BYTES);
                            core_d.st  = ST_COLLECT;
                        end
                    endcase
                end
            end

            ST_COLLECT: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    core_d.shreg = {core_q.shreg[DATA_W-9:0], cmd_byte};
                    core_d.cnt   = core_q.cnt - CNT_W'(1);
                    if (core_q.cnt == CNT_W'(1)) begin
                        core_d.st = ST_EXEC;
                    end
                end
            end

            ST_EXEC: begin
                core_d.st = ST_IDLE;
                case (core_q.cmd.kind)
                    OP_LDADDR: core_d.addr = ADDR_W'(core_q.shreg);
                    OP_REG_WR, OP_MEM_WR: begin
                        bus_req     = 1'b1;
                        bus_we      = 1'b1;
                        core_d.addr = core_q.addr + adv;
                        if (core_q.cmd.kind == OP_REG_WR && core_q.cmd.space == SPC_AUX
                            && core_q.shreg[RESUME_BIT]) begin
                            for (int k = 0; k < NPROC; k++) begin
                                if (core_q.addr == ADDR_W'(k)) begin
                                    resume[k] = 1'b1;
                                end
                            end
                        end
                    end
                    OP_REG_RD, OP_MEM_RD: begin
                        bus_req     = 1'b1;
                        core_d.addr = core_q.addr + adv;
                        core_d.st   = ST_WAIT;
                    end
                    OP_CTL_WR: ctl_we = 1'b1;
                    default: core_d.st = ST_IDLE;
                endcase
            end

            ST_WAIT: begin
                if (bus_rvalid) begin
                    tx_load   = 1'b1;
                    tx_word   = bus_rdata;
                    tx_cnt    = CNT_W'(BYTES);
                    core_d.st = ST_SEND;
                end
            end

            ST_SEND: begin
                if (tx_last) begin
                    core_d.st = ST_IDLE;
                end
            end

            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q.st        <= ST_IDLE;
            core_q.cmd.kind  <= OP_ILLEGAL;
            core_q.cmd.space <= SPC_NONE;
            core_q.cmd.incr  <= 1'b0;
            core_q.cnt       <= '0;
            core_q.shreg     <= '0;
            core_q.addr      <= '0;
        end else begin
            core_q <= core_d;
        end
    end

endmodule

// File: rtl/dbgp_port_chk.sv
module dbgp_port_chk #(
    parameter int NPROC = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [7:0]       rsp_byte,
    input logic             bus_req,
    input logic [1:0]       bus_space,
    input logic [NPROC-1:0] cpu_halt,
    input logic [NPROC-1:0] cpu_step
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cpu_halt == '1 && cpu_step == '0 && !rsp_valid));

    p_space_legal_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_space != 2'b11));

    p_req_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !rsp_valid);

    p_step_once_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_step != '0) |=> (cpu_step == '0));

    p_busy_blocks_cmd_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cmd_ready);

    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

endmodule

bind dbgp_port dbgp_port_chk #(.NPROC(NPROC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_byte  (rsp_byte),
    .bus_req   (bus_req),
    .bus_space (bus_space),
    .cpu_halt  (cpu_halt),
    .cpu_step  (cpu_step)
);

// File: tb/dbgp_port_test.sv
module dbgp_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        cmd_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_byte;
    logic        rsp_ready = 1'b1;
    logic        bus_req;
    logic        bus_we;
    logic [1:0]  bus_space;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = 32'h0;
    logic [2:0]  cpu_halt;
    logic [2:0]  cpu_step;

    always #5 clk = ~clk;

    dbgp_port uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_ready(rsp_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .cpu_halt(cpu_halt), .cpu_step(cpu_step)
    );

    int compared = 0;
    int mismatched = 0;

    // observation of the bus, the response stream and the step pulses
    int          req_count = 0;
    logic        last_we = 1'b0;
    logic [1:0]  last_space = 2'b00;
    logic [31:0] last_addr = 32'h0;
    logic [31:0] last_wdata = 32'h0;
    logic        rd_pend = 1'b0;
    logic [1:0]  pend_space = 2'b00;
    logic [31:0] pend_addr = 32'h0;
    logic [7:0]  rx_log [0:255];
    int          rx_n = 0;
    int          step_cycles = 0;
    logic [2:0]  last_step = 3'b000;

    function automatic logic [31:0] pattern(input logic [1:0] sp, input logic [31:0] a);
        return {6'b101100, sp, a[23:0]};
    endfunction

    always @(negedge clk) begin
        bus_rvalid = 1'b0;
        if (rd_pend) begin
            bus_rvalid = 1'b1;
            bus_rdata  = pattern(pend_space, pend_addr);
            rd_pend    = 1'b0;
        end
        if (bus_req) begin
            req_count++;
            last_we    = bus_we;
            last_space = bus_space;
            last_addr  = bus_addr;
            last_wdata = bus_wdata;
            if (!bus_we) begin
                rd_pend    = 1'b1;
                pend_space = bus_space;
                pend_addr  = bus_addr;
            end
        end
        if (rsp_valid && rsp_ready) begin
            if (rx_n < 256) rx_log[rx_n] = rsp_byte;
            rx_n++;
        end
        if (cpu_step != 3'b000) begin
            step_cycles++;
            last_step = cpu_step;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_word(input logic [7:0] op, input logic [31:0] w);
        send(op);
        for (int i = 3; i >= 0; i--) send(w[8*i +: 8]);
    endtask

    task automatic load_addr(input logic [31:0] a);
        send_word(8'h00, a);
    endtask

    task automatic collect(input int base, input int n, output logic [31:0] w);
        int guard;
        guard = 0;
        while (rx_n < base + n && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        idle(1);
        w = 32'h0;
        for (int i = 0; i < n; i++) w = {w[23:0], rx_log[base + i]};
    endtask

    task automatic read_op(input logic [7:0] op, input int n, output logic [31:0] w);
        int base;
        base = rx_n;
        send(op);
        collect(base, n, w);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        send(8'h02);
        send(v);
        idle(2);
    endtask

    task automatic t_reset();
        chk("R1 halt", {29'h0, cpu_halt}, 32'h7);
        chk("R1 step", {29'h0, cpu_step}, 32'h0);
        chk("R1 cmd_ready", {31'h0, cmd_ready}, 32'h1);
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk("R1 no request", req_count, 0);
    endtask

    task automatic t_reg_write();
        int base;
        load_addr(32'h1234_5678);
        base = req_count;
        send_word(8'h41, 32'hDEAD_BEEF);
        idle(2);
        chk("R3 one core write", req_count, base + 1);
        chk("R3 we", {31'h0, last_we}, 32'h1);
        chk("R3 core space", {30'h0, last_space}, 32'h0);
        chk("R2 address loaded", last_addr, 32'h1234_5678);
        chk("R3 wdata", last_wdata, 32'hDEAD_BEEF);
        send_word(8'h41, 32'h0BAD_F00D);
        idle(2);
        chk("R5 no increment", last_addr, 32'h1234_5678);
        load_addr(32'h40);
        send_word(8'hA1, 32'h11);
        idle(2);
        chk("R3 aux space", {30'h0, last_space}, 32'h1);
        send_word(8'h81, 32'h22);
        idle(2);
        chk("R5 aux post-increment", last_addr, 32'h41);
        chk("R3 aux wdata", last_wdata, 32'h22);
    endtask

    task automatic t_reg_read();
        logic [31:0] w;
        load_addr(32'h200);
        read_op(8'h51, 4, w);
        chk("R4 core read data", w, pattern(2'd0, 32'h200));
        chk("R4 read direction", {31'h0, last_we}, 32'h0);
        read_op(8'h71, 4, w);
        chk("R4 core read inc data", w, pattern(2'd0, 32'h200));
        read_op(8'h51, 4, w);
        chk("R5 read post-increment", last_addr, 32'h201);
        read_op(8'h91, 4, w);
        chk("R4 aux read data", w, pattern(2'd1, 32'h201));
    endtask

    task automatic t_mem();
        logic [31:0] w;
        load_addr(32'h100);
        send_word(8'h21, 32'hA5A5_0001);
        idle(2);
        chk("R6 mem write space", {30'h0, last_space}, 32'h2);
        chk("R6 mem write addr", last_addr, 32'h100);
        send_word(8'h21, 32'hA5A5_0002);
        idle(2);
        chk("R6 mem second addr", last_addr, 32'h104);
        chk("R6 mem wdata", last_wdata, 32'hA5A5_0002);
        read_op(8'h31, 4, w);
        chk("R6 mem read addr", last_addr, 32'h108);
        chk("R6 mem read data", w, pattern(2'd2, 32'h108));
    endtask

    task automatic t_ctl();
        int sbase;
        logic [31:0] w;
        sbase = step_cycles;
        // write then read with no gap: self-clear and capture on one edge
        send(8'h02);
        send(8'h05);
        read_op(8'h12, 1, w);
        chk("R8 step one cycle", step_cycles, sbase + 1);
        chk("R8 step bits", {29'h0, last_step}, 32'h5);
        chk("R7 halt cleared", {29'h0, cpu_halt}, 32'h0);
        chk("R8 read after step", w, 32'h00);
        ctl_write(8'h10);
        chk("R7 halt proc1", {29'h0, cpu_halt}, 32'h2);
        read_op(8'h12, 1, w);
        chk("R8 ctl readback", w, 32'h10);
    endtask

    task automatic t_resume();
        int base;
        ctl_write(8'h38);
        chk("R7 halt all", {29'h0, cpu_halt}, 32'h7);
        load_addr(32'h1);
        base = req_count;
        send_word(8'h81, 32'h0200_0000);
        idle(2);
        chk("R9 resume proc1", {29'h0, cpu_halt}, 32'h5);
        chk("R9 write still issued", req_count, base + 1);
        load_addr(32'h2);
        send_word(8'h81, 32'h0000_0001);
        idle(2);
        chk("R9 bit clear no effect", {29'h0, cpu_halt}, 32'h5);
        load_addr(32'h0);
        send_word(8'h41, 32'h0200_0000);
        idle(2);
        chk("R9 core write no effect", {29'h0, cpu_halt}, 32'h5);
    endtask

    task automatic t_bad();
        int rb;
        int xb;
        logic [31:0] w;
        rb = req_count;
        xb = rx_n;
        send(8'h77);
        idle(3);
        chk("R10 no request", req_count, rb);
        chk("R10 no response", rx_n, xb);
        chk("R10 ready for opcode", {31'h0, cmd_ready}, 32'h1);
        read_op(8'h12, 1, w);
        chk("R10 next opcode decoded", w, 32'h28);
    endtask

    task automatic t_stall();
        int base;
        int guard;
        logic [7:0] held;
        logic [31:0] w;
        rsp_ready = 1'b0;
        load_addr(32'h300);
        base = rx_n;
        send(8'h51);
        guard = 0;
        while (!rsp_valid && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        held = rsp_byte;
        idle(4);
        chk("R11 valid held", {31'h0, rsp_valid}, 32'h1);
        chk("R11 byte stable", {24'h0, rsp_byte}, {24'h0, held});
        chk("R11 cmd blocked", {31'h0, cmd_ready}, 32'h0);
        chk("R11 first byte msb", {24'h0, held}, 32'hB0);
        rsp_ready = 1'b1;
        collect(base, 4, w);
        chk("R11 data after stall", w, pattern(2'd0, 32'h300));
        chk("R11 ready after return", {31'h0, cmd_ready}, 32'h1);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_reg_write();
        t_reg_read();
        t_mem();
        t_ctl();
        t_resume();
        t_bad();
        t_stall();
        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule